// File: doc/BRIEF.md
# Instruction Fetch Translation Checker

This block sits beside the instruction translation buffer. It takes one fetch request at a time and decides whether the fetch may go ahead. Each request carries the fetch address, a misspeculation flag, the current privilege mode, the instruction page-table base and the result of the buffer lookup. The lookup result is a hit flag, a physical page number and one execute-enable bit per mode. The block answers one cycle later. The answer is either a physical address or a fault class with its trap vector.

Any fault that is not misspeculated does two more things. It stores the fetch address in a fault-tag register. It also stores a formatted fault address, built from the page-table base and the virtual page number, in a second register. Three counters keep the number of hits, misses and access violations, and the total access count is reported beside them.

The decision is a fixed sequence of checks:
1. Address range.
2. Superpage region.
3. Lookup hit.
4. Mode permission.

The registered response state names the outcome:
- `CK_IDLE`: no response this cycle.
- `CK_SUPER_OK`: superpage fetch in kernel mode.
- `CK_HIT_OK`: lookup hit with execute permission.
- `CK_ACV_RANGE`: address outside the valid range.
- `CK_ACV_SUPER`: superpage fetch outside kernel mode.
- `CK_ACV_PERM`: lookup hit without execute permission.
- `CK_MISS`: lookup miss.

Every clock edge moves the state to the outcome of the request presented in that cycle, or to `CK_IDLE` when no request is presented.

Top module: `itlb_fchk`

## Requirements
- R1: After reset the block holds all of these at zero: rsp_valid, rsp_fault, rsp_vector, rsp_paddr, both fault registers and all counters.
- R2: A fetch address is outside the valid range when bits 63..42 are not all equal. Such a fetch gets fault class 1 (access violation), whatever the lookup inputs are, and the violation counter increases by one.
- R3: A fetch address is in the superpage region when it is in range and bits 42..41 equal 2'b10. A superpage fetch in mode 0 (kernel) gets fault class 0 and a physical address equal to bits 40..0 of the fetch address. It changes no counter.
- R4: A superpage fetch in any mode other than 0 gets fault class 1, and the violation counter increases by one.
- R5: A fetch that is in range, outside the superpage region and a lookup miss gets fault class 2 (page fault) with vector 0x0181. The miss counter increases by one.
- R6: On a lookup hit, the execute-enable bit indexed by the mode decides the outcome. If that bit is clear, the fetch gets fault class 1, and the violation counter increases by one.
- R7: On a lookup hit with the enable bit set, the fetch gets fault class 0 and a physical address equal to {ppn, fetch address bits 12..0}. The hit counter increases by one.
- R8: A fault that is not misspeculated loads the tag register with the fetch address. The same fault loads the formatted register with `ptb | (fetch address bits 42..13 << 3)`. Both loads are visible in the response cycle.
- R9: A misspeculated fetch still reports its fault and still updates the counters. It leaves both fault registers unchanged.
- R10: cnt_access always equals cnt_hit plus cnt_miss. A single fetch increases at most one counter.
- R11: A response arrives exactly one cycle after each accepted request. With no request, rsp_valid is 0 and no counter moves.
- R12: The vector is 0x0081 for class 1, 0x0181 for class 2 and 0 for class 0. Every fault response reports a physical address of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request presented this cycle |
| req_pc | input | 64 | Fetch virtual address |
| req_misspec | input | 1 | Fetch is on a misspeculated path |
| cur_mode | input | 2 | Current privilege mode, 0 is kernel |
| ptb | input | 64 | Instruction page-table base |
| tlb_hit | input | 1 | Lookup found a valid entry |
| tlb_ppn | input | 28 | Physical page number from the lookup |
| tlb_xen | input | 4 | Execute-enable bit per mode |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 2 | Fault class: 0 none, 1 access violation, 2 page fault |
| rsp_vector | output | 16 | Trap vector of the fault |
| rsp_paddr | output | 41 | Physical address, zero on fault |
| ftag_q | output | 64 | Fault tag register |
| fva_form_q | output | 64 | Formatted fault address register |
| cnt_hit | output | 32 | Hit count |
| cnt_miss | output | 32 | Miss count |
| cnt_acv | output | 32 | Access-violation count |
| cnt_access | output | 32 | Hits plus misses |

## Verification
A wrong step in the check order shows up as a wrong fault class or vector in the very next response cycle. The same mistake also moves the wrong counter. A misrouted fault-register load shows up the same cycle, as a changed tag after a misspeculated fetch or a stale tag after a real fault. Random fetches across all four address regions, all modes and both lookup outcomes are mixed with directed edge cases, so each branch of the sequence is observed every few requests.

// File: rtl/itlb_fchk_pkg.sv
package itlb_fchk_pkg;

    typedef enum logic [1:0] {
        FC_NONE = 2'd0,
        FC_ACV  = 2'd1,
        FC_PGF  = 2'd2
    } fault_cls_e;

    typedef enum logic [2:0] {
        CK_IDLE      = 3'd0,
        CK_SUPER_OK  = 3'd1,
        CK_HIT_OK    = 3'd2,
        CK_ACV_RANGE = 3'd3,
        CK_ACV_SUPER = 3'd4,
        CK_ACV_PERM  = 3'd5,
        CK_MISS      = 3'd6
    } chk_state_e;

    localparam int NUM_CNT = 3;
    localparam int CNT_HIT = 0;
    localparam int CNT_MIS = 1;
    localparam int CNT_ACV = 2;

endpackage

// File: rtl/itlb_fchk_classify.sv
module itlb_fchk_classify
    import itlb_fchk_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int VA_W   = 43,
    parameter int MODE_W = 2
) (
    input  logic [ADDR_W-1:0]      pc,
    input  logic [MODE_W-1:0]      mode,
    input  logic                   hit,
    input  logic [(1<<MODE_W)-1:0] xen,
    output chk_state_e             outcome
);

    localparam int HI_W = ADDR_W - VA_W + 1;

    logic [HI_W-1:0] hi_bits;
    logic            in_range;
    logic            superpage;
    logic            kernel;
    logic            perm;

    always_comb begin
        hi_bits   = pc[ADDR_W-1:VA_W-1];
        in_range  = (&hi_bits) || !(|hi_bits);
        superpage = (pc[VA_W-1:VA_W-2] == 2'b10);
        kernel    = (mode == '0);
        perm      = xen[mode];
    end

    // fixed check order: range, superpage, lookup, permission
    always_comb begin
        if (!in_range)
            outcome = CK_ACV_RANGE;
        else if (superpage)
            outcome = kernel ? CK_SUPER_OK : CK_ACV_SUPER;
        else if (!hit)
            outcome = CK_MISS;
        else if (!perm)
            outcome = CK_ACV_PERM;
        else
            outcome = CK_HIT_OK;
    end

endmodule

// File: rtl/itlb_fchk_fault_regs.sv
module itlb_fchk_fault_regs #(
    parameter int ADDR_W     = 64,
    parameter int VA_W       = 43,
    parameter int PAGE_SHIFT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] ptb,
    output logic [ADDR_W-1:0] tag_q,
    output logic [ADDR_W-1:0] form_q
);

    localparam int VPN_W = VA_W - PAGE_SHIFT;

    logic [ADDR_W-1:0] vpn_ext;
    logic [ADDR_W-1:0] form_d;

    always_comb begin
        vpn_ext = ADDR_W'(pc[VA_W-1:PAGE_SHIFT]);
        form_d  = ptb | (vpn_ext << 3);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            form_q <= '0;
        end else if (load) begin
            tag_q  <= pc;
            form_q <= form_d;
        end
    end

    AST_FORM_LOW_FROM_PTB: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> form_q[2:0] == $past(ptb[2:0])); // R8

    AST_TAG_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(tag_q) && $stable(form_q)); // R9

endmodule

// File: rtl/itlb_fchk_counters.sv
module itlb_fchk_counters #(
    parameter int NUM   = 3,
    parameter int CNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM-1:0]            inc,
    output logic [NUM-1:0][CNT_W-1:0] cnt
);

    for (genvar g = 0; g < NUM; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt[g] <= '0;
            else if (inc[g])
                cnt[g] <= cnt[g] + CNT_W'(1);
        end

        AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            inc[g] |=> cnt[g] == $past(cnt[g]) + CNT_W'(1)); // R10
    end

    AST_ONE_INC: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(inc) <= 1); // R10

endmodule

// File: rtl/itlb_fchk.sv
module itlb_fchk
    import itlb_fchk_pkg::*;
#(
    parameter int          ADDR_W     = 64,
    parameter int          VA_W       = 43,
    parameter int          PA_W       = 41,
    parameter int          PAGE_SHIFT = 13,
    parameter int          MODE_W     = 2,
    parameter int          CNT_W      = 32,
    parameter int          VEC_W      = 16,
    parameter logic [15:0] VEC_MISS   = 16'h0181,
    parameter logic [15:0] VEC_ACV    = 16'h0081
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [ADDR_W-1:0]          req_pc,
    input  logic                       req_misspec,
    input  logic [MODE_W-1:0]          cur_mode,
    input  logic [ADDR_W-1:0]          ptb,
    input  logic                       tlb_hit,
    input  logic [PA_W-PAGE_SHIFT-1:0] tlb_ppn,
    input  logic [(1<<MODE_W)-1:0]     tlb_xen,
    output logic                       rsp_valid,
    output logic [1:0]                 rsp_fault,
    output logic [VEC_W-1:0]           rsp_vector,
    output logic [PA_W-1:0]            rsp_paddr,
    output logic [ADDR_W-1:0]          ftag_q,
    output logic [ADDR_W-1:0]          fva_form_q,
    output logic [CNT_W-1:0]           cnt_hit,
    output logic [CNT_W-1:0]           cnt_miss,
    output logic [CNT_W-1:0]           cnt_acv,
    output logic [CNT_W-1:0]           cnt_access
);

    localparam int PPN_W = PA_W - PAGE_SHIFT;

    chk_state_e                      outcome;
    chk_state_e                      state_q;
    chk_state_e                      state_d;
    logic [PA_W-1:0]                 paddr_d;
    logic [PA_W-1:0]                 paddr_q;
    logic                            is_fault_d;
    logic                            fault_load;
    logic [NUM_CNT-1:0]              inc;
    logic [NUM_CNT-1:0][CNT_W-1:0]   cnt;

    itlb_fchk_classify #(
        .ADDR_W (ADDR_W),
        .VA_W   (VA_W),
        .MODE_W (MODE_W)
    ) u_classify (
        .pc      (req_pc),
        .mode    (cur_mode),
        .hit     (tlb_hit),
        .xen     (tlb_xen),
        .outcome (outcome)
    );

    // next state and physical address
    always_comb begin
        state_d = req_valid ? outcome : CK_IDLE;
        paddr_d = '0;
        unique case (state_d)
            CK_SUPER_OK: paddr_d = req_pc[PA_W-1:0];
            CK_HIT_OK:   paddr_d = {tlb_ppn, req_pc[PAGE_SHIFT-1:0]};
            default:     paddr_d = '0;
        endcase
        is_fault_d = req_valid && (outcome inside {CK_ACV_RANGE, CK_ACV_SUPER,
                                                   CK_ACV_PERM, CK_MISS});
        fault_load = is_fault_d && !req_misspec;
        inc[CNT_HIT] = (state_d == CK_HIT_OK);
        inc[CNT_MIS] = (state_d == CK_MISS);
        inc[CNT_ACV] = state_d inside {CK_ACV_RANGE, CK_ACV_SUPER, CK_ACV_PERM};
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CK_IDLE;
            paddr_q <= '0;
        end else begin
            state_q <= state_d;
            paddr_q <= paddr_d;
        end
    end

    // outputs from state
    always_comb begin
        rsp_valid  = (state_q != CK_IDLE);
        rsp_paddr  = paddr_q;
        rsp_fault  = FC_NONE;
        rsp_vector = '0;
        unique case (state_q)
            CK_IDLE, CK_SUPER_OK, CK_HIT_OK: begin
                rsp_fault  = FC_NONE;
                rsp_vector = '0;
            end
            CK_ACV_RANGE, CK_ACV_SUPER, CK_ACV_PERM: begin
                rsp_fault  = FC_ACV;
                rsp_vector = VEC_W'(VEC_ACV);
            end
            CK_MISS: begin
                rsp_fault  = FC_PGF;
                rsp_vector = VEC_W'(VEC_MISS);
            end
            default: begin
                rsp_fault  = FC_NONE;
                rsp_vector = '0;
            end
        endcase
    end

    itlb_fchk_fault_regs #(
        .ADDR_W     (ADDR_W),
        .VA_W       (VA_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_fault_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (fault_load),
        .pc     (req_pc),
        .ptb    (ptb),
        .tag_q  (ftag_q),
        .form_q (fva_form_q)
    );

    itlb_fchk_counters #(
        .NUM   (NUM_CNT),
        .CNT_W (CNT_W)
    ) u_counters (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc),
        .cnt   (cnt)
    );

    always_comb begin
        cnt_hit    = cnt[CNT_HIT];
        cnt_miss   = cnt[CNT_MIS];
        cnt_acv    = cnt[CNT_ACV];
        cnt_access = cnt[CNT_HIT] + cnt[CNT_MIS];
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R11

    AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && $stable(cnt_access) && $stable(cnt_acv)); // R11

    AST_MISSPEC_HOLDS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_misspec |=> $stable(ftag_q) && $stable(fva_form_q)); // R9

    AST_TAG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        is_fault_d && !req_misspec |=> ftag_q == $past(req_pc)); // R8

    AST_MISS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault == FC_PGF |-> rsp_vector == VEC_W'(VEC_MISS)); // R5

    AST_FAULT_NO_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault != FC_NONE |-> rsp_paddr == '0); // R12

    AST_RANGE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !((&req_pc[ADDR_W-1:VA_W-1]) || !(|req_pc[ADDR_W-1:VA_W-1]))
        |=> rsp_fault == FC_ACV); // R2

endmodule

// File: tb/tb_itlb_fchk.sv
module tb_itlb_fchk;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_pc = '0;
    logic        req_misspec = 1'b0;
    logic [1:0]  cur_mode = '0;
    logic [63:0] ptb = '0;
    logic        tlb_hit = 1'b0;
    logic [27:0] tlb_ppn = '0;
    logic [3:0]  tlb_xen = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_fault;
    logic [15:0] rsp_vector;
    logic [40:0] rsp_paddr;
    logic [63:0] ftag_q, fva_form_q;
    logic [31:0] cnt_hit, cnt_miss, cnt_acv, cnt_access;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] e_hit = 0, e_miss = 0, e_acv = 0;
    logic [63:0] e_tag = 0, e_form = 0;

    always #4 clk = ~clk;

    itlb_fchk dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
        .req_misspec(req_misspec), .cur_mode(cur_mode), .ptb(ptb),
        .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_xen(tlb_xen),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_vector(rsp_vector),
        .rsp_paddr(rsp_paddr), .ftag_q(ftag_q), .fva_form_q(fva_form_q),
        .cnt_hit(cnt_hit), .cnt_miss(cnt_miss), .cnt_acv(cnt_acv),
        .cnt_access(cnt_access)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected class: 0 none, 1 violation, 2 page fault
    function automatic logic [1:0] exp_cls(input logic [63:0] pc, input logic [1:0] m,
                                           input logic h, input logic [3:0] x);
        logic in_rng;
        in_rng = (pc[63:42] == 22'h3FFFFF) || (pc[63:42] == 22'h0);
        if (!in_rng) return 2'd1;
        if (pc[42:41] == 2'b10) return (m == 2'd0) ? 2'd0 : 2'd1;
        if (!h) return 2'd2;
        if (!x[m]) return 2'd1;
        return 2'd0;
    endfunction

    task automatic fetch(input logic [63:0] pc, input logic ms, input logic [1:0] m,
                         input logic [63:0] b, input logic h, input logic [27:0] p,
                         input logic [3:0] x, input string req);
        logic [1:0]  cls;
        logic [40:0] pa;
        logic [15:0] vec;
        cls = exp_cls(pc, m, h, x);
        pa  = '0;
        if (cls == 2'd0)
            pa = (pc[42:41] == 2'b10) ? pc[40:0] : {p, pc[12:0]};
        vec = (cls == 2'd1) ? 16'h0081 : (cls == 2'd2) ? 16'h0181 : 16'h0000;
        if (cls == 2'd1) e_acv++;
        if (cls == 2'd2) e_miss++;
        if (cls == 2'd0 && pc[42:41] != 2'b10) e_hit++;
        if (cls != 2'd0 && !ms) begin
            e_tag  = pc;
            e_form = b | ({34'b0, pc[42:13]} << 3);
        end
        @(negedge clk);
        req_valid = 1'b1; req_pc = pc; req_misspec = ms; cur_mode = m;
        ptb = b; tlb_hit = h; tlb_ppn = p; tlb_xen = x;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid === 1'b1, {req, " valid"}, 64'(rsp_valid), 64'd1);
        check(rsp_fault === cls, {req, " class"}, 64'(rsp_fault), 64'(cls));
        check(rsp_vector === vec, {req, "/R12 vector"}, 64'(rsp_vector), 64'(vec));
        check(rsp_paddr === pa, {req, " paddr"}, 64'(rsp_paddr), 64'(pa));
        check(ftag_q === e_tag, {req, "/R8/R9 tag"}, ftag_q, e_tag);
        check(fva_form_q === e_form, {req, "/R8/R9 form"}, fva_form_q, e_form);
        check(cnt_hit === e_hit && cnt_miss === e_miss && cnt_acv === e_acv,
              {req, " counters"}, {cnt_hit, cnt_acv}, {e_hit, e_acv});
        check(cnt_access === e_hit + e_miss, "R10 access sum", 64'(cnt_access),
              64'(e_hit + e_miss));
    endtask

    initial begin : main
        logic [63:0] pc;
        int unsigned seed;
        seed = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        check(rsp_valid === 0 && rsp_fault === 0 && rsp_vector === 0 && rsp_paddr === 0,
              "R1 reset outputs", 64'(rsp_paddr), 64'd0);
        check(ftag_q === 0 && fva_form_q === 0 && cnt_hit === 0 && cnt_miss === 0 &&
              cnt_acv === 0 && cnt_access === 0, "R1 reset state", ftag_q, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corner cases
        fetch(64'h8000_0000_0000_1000, 0, 2'd0, 64'hF000_0000, 1, 28'h123, 4'hF, "R2 range");
        fetch(64'h0000_0400_0000_0000, 0, 2'd0, 64'h0, 1, 28'h1, 4'hF, "R2 range boundary");
        fetch(64'hFFFF_FC12_3456_789A, 0, 2'd0, 64'h0, 0, 28'h0, 4'h0, "R3 superpage kernel");
        fetch(64'hFFFF_FC12_3456_7898, 0, 2'd3, 64'h4000, 0, 28'h0, 4'hF, "R4 superpage user");
        fetch(64'h0000_0000_0040_2004, 0, 2'd1, 64'h8000, 0, 28'h0, 4'hF, "R5 miss");
        fetch(64'h0000_0000_0040_2008, 0, 2'd2, 64'h8000, 1, 28'hABC, 4'b1011, "R6 perm clear");
        fetch(64'h0000_0000_0040_3FFC, 0, 2'd2, 64'h8000, 1, 28'hABC, 4'b0100, "R7 hit");
        fetch(64'h0000_0000_0077_7000, 1, 2'd0, 64'h9000, 0, 28'h0, 4'hF, "R9 misspec miss");
        fetch(64'hFFFF_FE00_0000_0000, 0, 2'd0, 64'h0, 1, 28'h5, 4'h1, "R7 upper hit");

        // idle cycle: no response, counters held
        @(negedge clk);
        check(rsp_valid === 1'b0, "R11 idle no response", 64'(rsp_valid), 64'd0);
        check(cnt_hit === e_hit && cnt_miss === e_miss && cnt_acv === e_acv,
              "R11 idle counters", 64'(cnt_acv), 64'(e_acv));

        // random mix over regions, modes and lookup outcomes
        for (int i = 0; i < 400; i++) begin
            pc = {$urandom, $urandom};
            case ($urandom % 4)
                0: begin pc[63] = 1'b0; pc[50] = 1'b1; end
                1: pc[63:41] = 23'h7FFFFE;
                2: pc[63:41] = 23'h0;
                default: pc[63:41] = 23'h7FFFFF;
            endcase
            fetch(pc, ($urandom % 4) == 0, 2'($urandom), {$urandom, $urandom},
                  ($urandom % 3) != 0, 28'($urandom), 4'($urandom),
                  "R2/R3/R4/R5/R6/R7 random");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule